// File: doc/BRIEF.md
# Core-to-Mesh Network Interface

This block sits between one processing core and the local port of its mesh router. The core sees a small register window behind a single-beat AXI4 slave port. To send a packet, the core writes a header word that names the destination and the payload length. It then writes that many payload words. The block turns this sequence into a stream of flits, each tagged with a 2-bit type. It pushes the flits across a dual-clock FIFO and injects them into the router under credit-based flow control.

Flits arriving from the router cross a second dual-clock FIFO into the core clock domain. There they are appended to a read buffer. A packet's words become visible only once its closing flit has arrived. When the number of visible words rises above a programmable threshold, the interrupt line is raised. The receive-data register can only be drained while that line is high, so inbound data is consumed from the service routine rather than by polling.

Register map, as byte addresses:

| Address | Register |
|---------|----------|
| 0x00 | Transmit header |
| 0x04 | Transmit data |
| 0x08 | Receive data |
| 0x0C | Threshold |
| 0x10 | Status |

The header word has three fields:

| Bits | Field |
|------|-------|
| [7:0] | X coordinate |
| [15:8] | Y coordinate |
| [23:16] | Payload length |

Each flit is `{type[1:0], word[31:0]}`. The type codes are head 00, body 01, tail 10 and single 11.

Top module: `core_mesh_nif`

## Requirements
- R1: Every write and read on the slave port is a single beat. The response carries OKAY (00), and bvalid/rvalid with rdata stay unchanged until bready/rready accept them.
- R2: A header write while no packet is open sends one flit carrying the written word unchanged. Its type is head (00) when the length field [23:16] is non-zero, and single (11) when it is zero.
- R3: Each data write to an open packet sends one flit carrying the word unchanged, in write order. The flit that completes the announced length is typed tail (10); all earlier ones are typed body (01).
- R4: A data write while no packet is open sends nothing. A header write while a packet is open sends nothing and does not change the packet in progress.
- R5: At most CREDITS flits are outstanding toward the router. Each cycle with tx_credit high returns one credit, and a flit is never presented without a credit.
- R6: Every inbound flit word, including the head, is appended to the read buffer in arrival order. A packet's words count toward occupancy only once its tail or single flit has arrived.
- R7: irq is high exactly while the occupancy is greater than the threshold register (address 0x0C, reset 0).
- R8: A read of address 0x08 while irq is high returns the oldest buffered word and removes it. While irq is low, the read returns 0 and removes nothing.
- R9: A flit that arrives while the read buffer holds 2^RXB_AW words is dropped and sets the sticky overflow bit (status bit 17). Writing 1 to bit 17 of address 0x10 clears it.
- R10: Status (address 0x10) reports the occupancy in bits [RXB_AW:0], irq in bit 16, overflow in bit 17, and an open transmit packet in bit 18.
- R11: After reset, irq and tx_flit_valid are low, rx_flit_ready is high, and the status and threshold registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| irq | output | 1 | Read buffer above threshold |
| net_clk | input | 1 | Router clock |
| net_rst_n | input | 1 | Router-domain reset, active low |
| tx_flit_valid | output | 1 | Outbound flit valid, consumed on the same edge |
| tx_flit | output | DATA_W+2 | Outbound flit |
| tx_credit | input | 1 | One credit returned from the router |
| rx_flit_valid | input | 1 | Inbound flit valid |
| rx_flit | input | DATA_W+2 | Inbound flit |
| rx_flit_ready | output | 1 | Inbound crossing FIFO has room |

## Verification
The bench uses the default build: 32-bit words, 4-entry crossing FIFOs, an 8-word read buffer and 4 credits. The router clock runs at a period unrelated to the core clock.

With only four credits, a six-flit packet stalls after four flits until credits are handed back. The small read buffer lets nine single-flit packets reach the overflow case quickly.

Setting the threshold first to 2, then to 0, then to the full depth covers three situations:
- A partly drained buffer where the receive-data read is gated off.
- A buffer drained completely.
- A buffer that fills without ever raising irq.

// File: rtl/nif_afifo.sv
module nif_afifo #(
  parameter int W  = 34,
  parameter int AW = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         winc,
  input  logic [W-1:0] wdata,
  output logic         wfull,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rinc,
  output logic [W-1:0] rdata,
  output logic         rempty
);
  localparam int D = 1 << AW;
  localparam logic [AW:0] FULL_FLIP = {2'b11, {(AW-1){1'b0}}};

  logic [W-1:0] mem [D];
  logic [AW:0] wbin, wgray, wq1, wq2, rbin, rgray, rq1, rq2;

  wire [AW:0] wbin_n  = wbin + {{AW{1'b0}}, winc & ~wfull};
  wire [AW:0] wgray_n = (wbin_n >> 1) ^ wbin_n;
  wire [AW:0] rbin_n  = rbin + {{AW{1'b0}}, rinc & ~rempty};
  wire [AW:0] rgray_n = (rbin_n >> 1) ^ rbin_n;

  always_ff @(posedge wclk)
    if (winc && !wfull) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; wq1 <= '0; wq2 <= '0; wfull <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wgray_n;
      wq1   <= rgray;
      wq2   <= wq1;
      wfull <= wgray_n == (wq2 ^ FULL_FLIP);
    end

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; rq1 <= '0; rq2 <= '0; rempty <= 1'b1;
    end else begin
      rbin   <= rbin_n;
      rgray  <= rgray_n;
      rq1    <= wgray;
      rq2    <= rq1;
      rempty <= rgray_n == rq2;
    end

  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/core_mesh_nif.sv
module core_mesh_nif #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int FIFO_AW = 2,
  parameter int RXB_AW  = 3,
  parameter int CREDITS = 4
) (
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              irq,
  input  logic              net_clk,
  input  logic              net_rst_n,
  output logic              tx_flit_valid,
  output logic [DATA_W+1:0] tx_flit,
  input  logic              tx_credit,
  input  logic              rx_flit_valid,
  input  logic [DATA_W+1:0] rx_flit,
  output logic              rx_flit_ready
);
  localparam int FLIT_W = DATA_W + 2;
  localparam int OCC_W  = RXB_AW + 1;
  localparam int RXB_D  = 1 << RXB_AW;
  localparam int CRW    = $clog2(CREDITS + 1);
  localparam logic [ADDR_W-1:0] A_HDR = ADDR_W'(0),  A_DAT = ADDR_W'(4),
                                A_RX  = ADDR_W'(8),  A_THR = ADDR_W'(12),
                                A_ST  = ADDR_W'(16);
  localparam logic [1:0] T_HEAD = 2'b00, T_BODY = 2'b01, T_TAIL = 2'b10, T_ONE = 2'b11;

  // core side: transmit segmentation
  logic [7:0] tx_rem;
  logic [1:0] tx_type;
  logic       txq_full;
  wire tx_open  = tx_rem != 8'd0;
  wire wr_is_tx = (s_awaddr == A_HDR) || (s_awaddr == A_DAT);
  wire wr_go    = s_awvalid & s_wvalid & ~s_bvalid & ~(wr_is_tx & txq_full);
  wire hdr_push = wr_go && s_awaddr == A_HDR && !tx_open;
  wire dat_push = wr_go && s_awaddr == A_DAT && tx_open;
  wire [7:0] hlen = s_wdata[23:16];

  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;

  always_comb
    if (hdr_push) tx_type = (hlen == 8'd0) ? T_ONE : T_HEAD;
    else          tx_type = (tx_rem == 8'd1) ? T_TAIL : T_BODY;

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) tx_rem <= 8'd0;
    else if (hdr_push) tx_rem <= hlen;
    else if (dat_push) tx_rem <= tx_rem - 8'd1;

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) s_bvalid <= 1'b0;
    else if (wr_go) s_bvalid <= 1'b1;
    else if (s_bready) s_bvalid <= 1'b0;

  // core side: receive reassembly and read buffer
  logic [FLIT_W-1:0] rxq_rdata;
  logic              rxq_empty;
  logic [DATA_W-1:0] rxb [RXB_D];
  logic [OCC_W-1:0]  wp, cp, rp, thr;
  logic              ovf;

  wire [OCC_W-1:0] fill = wp - rp;
  wire [OCC_W-1:0] occ  = cp - rp;
  wire rxb_full  = fill == OCC_W'(RXB_D);
  wire flit_in   = ~rxq_empty;
  wire flit_keep = flit_in & ~rxb_full;
  wire flit_end  = flit_in && (rxq_rdata[FLIT_W-1:DATA_W] == T_TAIL ||
                               rxq_rdata[FLIT_W-1:DATA_W] == T_ONE);
  wire rd_go     = s_arvalid & ~s_rvalid;
  wire rx_read   = rd_go && s_araddr == A_RX && irq;

  assign irq       = occ > thr;
  assign s_arready = rd_go;

  always_ff @(posedge core_clk)
    if (flit_keep) rxb[wp[RXB_AW-1:0]] <= rxq_rdata[DATA_W-1:0];

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) begin
      wp <= '0; cp <= '0; rp <= '0;
    end else begin
      if (flit_keep) wp <= wp + OCC_W'(1);
      if (flit_end)  cp <= wp + OCC_W'(flit_keep);
      if (rx_read)   rp <= rp + OCC_W'(1);
    end

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) thr <= '0;
    else if (wr_go && s_awaddr == A_THR) thr <= s_wdata[OCC_W-1:0];

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) ovf <= 1'b0;
    else if (flit_in && rxb_full) ovf <= 1'b1;
    else if (wr_go && s_awaddr == A_ST && s_wdata[17]) ovf <= 1'b0;

  wire [DATA_W-1:0] status = {{(DATA_W-19){1'b0}}, tx_open, ovf, irq,
                              {(16-OCC_W){1'b0}}, occ};

  always_ff @(posedge core_clk or negedge core_rst_n)
    if (!core_rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_go) begin
      s_rvalid <= 1'b1;
      case (s_araddr)
        A_RX:    s_rdata <= irq ? rxb[rp[RXB_AW-1:0]] : '0;
        A_THR:   s_rdata <= DATA_W'(thr);
        A_ST:    s_rdata <= status;
        default: s_rdata <= '0;
      endcase
    end else if (s_rready) s_rvalid <= 1'b0;

  // network side: credit-controlled injection
  logic [FLIT_W-1:0] txq_rdata;
  logic              txq_empty, rxq_full;
  logic [CRW-1:0]    crd;

  assign tx_flit_valid = ~txq_empty && crd != '0;
  assign tx_flit       = txq_rdata;
  assign rx_flit_ready = ~rxq_full;

  always_ff @(posedge net_clk or negedge net_rst_n)
    if (!net_rst_n) crd <= CRW'(CREDITS);
    else crd <= crd - CRW'(tx_flit_valid) + CRW'(tx_credit);

  nif_afifo #(.W(FLIT_W), .AW(FIFO_AW)) u_txq (
    .wclk(core_clk), .wrst_n(core_rst_n), .winc(hdr_push | dat_push),
    .wdata({tx_type, s_wdata}), .wfull(txq_full),
    .rclk(net_clk), .rrst_n(net_rst_n), .rinc(tx_flit_valid),
    .rdata(txq_rdata), .rempty(txq_empty));

  nif_afifo #(.W(FLIT_W), .AW(FIFO_AW)) u_rxq (
    .wclk(net_clk), .wrst_n(net_rst_n), .winc(rx_flit_valid & rx_flit_ready),
    .wdata(rx_flit), .wfull(rxq_full),
    .rclk(core_clk), .rrst_n(core_rst_n), .rinc(flit_in),
    .rdata(rxq_rdata), .rempty(rxq_empty));
endmodule

// File: rtl/core_mesh_nif_chk.sv
module core_mesh_nif_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int CREDITS = 4
) (
  input logic              core_clk,
  input logic              core_rst_n,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              irq,
  input logic              net_clk,
  input logic              net_rst_n,
  input logic              tx_flit_valid,
  input logic [1:0]        tx_type,
  input logic              tx_credit
);
  localparam logic [7:0] CR8 = 8'(CREDITS);
  logic [7:0] outst;
  logic       in_pkt;

  always_ff @(posedge net_clk or negedge net_rst_n)
    if (!net_rst_n) begin
      outst  <= 8'd0;
      in_pkt <= 1'b0;
    end else begin
      outst <= outst + 8'(tx_flit_valid) - 8'(tx_credit);
      if (tx_flit_valid) in_pkt <= ~tx_type[1];
    end

  // R5
  credit_limit_chk: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    tx_flit_valid |-> outst < CR8);

  // R3
  body_tail_chk: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    tx_flit_valid && in_pkt |-> (tx_type == 2'b01 || tx_type == 2'b10));

  // R2
  pkt_start_chk: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    tx_flit_valid && !in_pkt |-> (tx_type == 2'b00 || tx_type == 2'b11));

  // R1
  bresp_hold_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    s_bvalid && !s_bready |=> s_bvalid);

  // R1
  rdata_hold_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  // R8
  gated_read_chk: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    s_arvalid && s_arready && s_araddr == ADDR_W'(8) && !irq |=> s_rdata == '0);
endmodule

bind core_mesh_nif core_mesh_nif_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CREDITS(CREDITS)) u_chk (
  .core_clk(core_clk), .core_rst_n(core_rst_n),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
  .irq(irq), .net_clk(net_clk), .net_rst_n(net_rst_n),
  .tx_flit_valid(tx_flit_valid), .tx_type(tx_flit[DATA_W+1:DATA_W]),
  .tx_credit(tx_credit));

// File: tb/tb_core_mesh_nif.sv
`timescale 1ns/1ps
module tb_core_mesh_nif;
  localparam int DW = 32, CR = 4, RXD = 8;

  logic core_clk = 0, net_clk = 0, core_rst_n = 0, net_rst_n = 0;
  logic [4:0] s_awaddr = 0, s_araddr = 0;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
  logic s_bready = 1, s_rready = 1;
  logic [DW-1:0] s_wdata = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, irq;
  logic [1:0] s_bresp, s_rresp;
  logic [DW-1:0] s_rdata;
  logic tx_flit_valid, rx_flit_ready;
  logic [DW+1:0] tx_flit;
  logic tx_credit = 0, rx_flit_valid = 0;
  logic [DW+1:0] rx_flit = 0;

  always #2 core_clk = ~core_clk;
  always #3 net_clk = ~net_clk;

  core_mesh_nif dut (.*);

  int nchk = 0, nerr = 0, rec_n = 0, pend = 0;
  bit credit_en = 1;
  logic [DW+1:0] rec [64];

  always @(negedge net_clk) begin
    tx_credit = 0;
    if (tx_flit_valid && rec_n < 64) begin rec[rec_n] = tx_flit; rec_n++; pend++; end
    if (credit_en && pend > 0) begin tx_credit = 1; pend--; end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [4:0] a, input logic [DW-1:0] d);
    @(negedge core_clk); s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1; #1;
    while (!s_awready) begin @(negedge core_clk); #1; end
    @(negedge core_clk); s_awvalid = 0; s_wvalid = 0;
    chk(s_bvalid && s_bresp == 2'b00, "R1 write response", {s_bvalid, s_bresp}, 3'b100);
  endtask

  task automatic rd(input logic [4:0] a, output logic [DW-1:0] d);
    @(negedge core_clk); s_araddr = a; s_arvalid = 1; #1;
    while (!s_arready) begin @(negedge core_clk); #1; end
    @(negedge core_clk); s_arvalid = 0;
    d = s_rdata;
    if (!s_rvalid) chk(0, "R1 read valid", 0, 1);
  endtask

  task automatic rx_send(input logic [1:0] t, input logic [DW-1:0] d);
    @(negedge net_clk);
    while (!rx_flit_ready) @(negedge net_clk);
    rx_flit_valid = 1; rx_flit = {t, d};
    @(negedge net_clk); rx_flit_valid = 0;
  endtask

  task automatic wait_flits(input int n);
    for (int i = 0; i < 400 && rec_n < n; i++) @(negedge net_clk);
  endtask

  localparam logic [DW-1:0] PKT_TAB [4] = '{32'h0000_0102, 32'h0001_0304,
                                            32'h0003_0506, 32'h0006_0708};
  function automatic logic [DW-1:0] pay(input int i, input int k);
    return 32'hC0DE_0000 | DW'(i << 8) | DW'(k);
  endfunction

  initial begin
    repeat (200000) @(posedge core_clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int base;
    repeat (5) @(negedge net_clk);
    core_rst_n = 1; net_rst_n = 1;
    repeat (6) @(negedge core_clk);
    // R11 reset state
    chk(!irq && !tx_flit_valid && rx_flit_ready, "R11 pins", {irq, tx_flit_valid, rx_flit_ready}, 3'b001);
    rd(5'h10, v); chk(v == 0, "R11 status", v, 0);
    rd(5'h0C, v); chk(v == 0, "R11 threshold", v, 0);

    // R2 R3 packet table
    for (int i = 0; i < 4; i++) begin
      int len;
      len = int'(PKT_TAB[i][23:16]);
      base = rec_n;
      wr(5'h00, PKT_TAB[i]);
      for (int k = 0; k < len; k++) wr(5'h04, pay(i, k));
      wait_flits(base + len + 1);
      chk(rec_n == base + len + 1, "R3 flit count", rec_n - base, len + 1);
      chk(rec[base] == {(len == 0) ? 2'b11 : 2'b00, PKT_TAB[i]}, "R2 head flit", rec[base],
          {(len == 0) ? 2'b11 : 2'b00, PKT_TAB[i]});
      for (int k = 1; k <= len; k++)
        chk(rec[base+k] == {(k == len) ? 2'b10 : 2'b01, pay(i, k-1)}, "R3 body/tail flit",
            rec[base+k], {(k == len) ? 2'b10 : 2'b01, pay(i, k-1)});
    end

    // R4 data with no packet open, header while open
    base = rec_n;
    wr(5'h04, 32'hDEAD_0001);
    repeat (40) @(negedge net_clk);
    chk(rec_n == base, "R4 stray data sent nothing", rec_n - base, 0);
    rd(5'h10, v); chk(v[18] == 0, "R4 no packet open", v[18], 0);
    wr(5'h00, 32'h0002_0001);
    wr(5'h00, 32'h0005_0009);
    rd(5'h10, v); chk(v[18] == 1, "R10 tx open bit", v[18], 1);
    wr(5'h04, 32'h1111_0000);
    wr(5'h04, 32'h2222_0000);
    wait_flits(base + 3);
    repeat (40) @(negedge net_clk);
    chk(rec_n == base + 3, "R4 second header ignored", rec_n - base, 3);
    chk(rec[base] == {2'b00, 32'h0002_0001}, "R4 header kept", rec[base], {2'b00, 32'h0002_0001});
    chk(rec[base+2] == {2'b10, 32'h2222_0000}, "R4 tail", rec[base+2], {2'b10, 32'h2222_0000});

    // R5 credit starvation
    credit_en = 0;
    base = rec_n;
    wr(5'h00, 32'h0005_0000);
    for (int k = 0; k < 5; k++) wr(5'h04, pay(9, k));
    repeat (60) @(negedge net_clk);
    chk(rec_n - base == CR, "R5 stall at credit limit", rec_n - base, CR);
    credit_en = 1;
    wait_flits(base + 6);
    chk(rec_n - base == 6, "R5 resume after credits", rec_n - base, 6);
    chk(rec[base+5] == {2'b10, pay(9, 4)}, "R5 last flit", rec[base+5], {2'b10, pay(9, 4)});

    // R6 R7 R8 reassembly, threshold, gated read
    wr(5'h0C, 2);
    rx_send(2'b00, 32'hAAAA_0000);
    rx_send(2'b01, 32'hAAAA_0001);
    rx_send(2'b01, 32'hAAAA_0002);
    repeat (30) @(negedge core_clk);
    rd(5'h10, v); chk(v[16:0] == 0, "R6 partial packet not counted", v, 0);
    chk(!irq, "R7 irq low", irq, 0);
    rd(5'h08, v); chk(v == 0, "R8 gated read", v, 0);
    rx_send(2'b10, 32'hAAAA_0003);
    repeat (30) @(negedge core_clk);
    rd(5'h10, v); chk(v[16:0] == 17'h10004, "R7 occ 4 irq", v, 32'h10004);
    rd(5'h08, v); chk(v == 32'hAAAA_0000, "R6 head word first", v, 32'hAAAA_0000);
    rd(5'h08, v); chk(v == 32'hAAAA_0001, "R6 order", v, 32'hAAAA_0001);
    repeat (2) @(negedge core_clk);
    chk(!irq, "R7 irq drops at threshold", irq, 0);
    rd(5'h08, v); chk(v == 0, "R8 read while not pending", v, 0);
    rd(5'h10, v); chk(v[16:0] == 2, "R8 nothing removed", v, 2);
    wr(5'h0C, 0);
    chk(irq, "R7 irq with threshold 0", irq, 1);
    rd(5'h08, v); chk(v == 32'hAAAA_0002, "R8 drain", v, 32'hAAAA_0002);
    rd(5'h08, v); chk(v == 32'hAAAA_0003, "R8 drain tail", v, 32'hAAAA_0003);
    rd(5'h10, v); chk(v[16:0] == 0, "R7 empty", v, 0);

    // R9 overflow
    wr(5'h0C, RXD);
    for (int k = 0; k < RXD + 1; k++) rx_send(2'b11, 32'h5500_0000 | k);
    repeat (30) @(negedge core_clk);
    chk(!irq, "R7 irq stays low at occ==threshold", irq, 0);
    rd(5'h10, v); chk(v[17] && v[RXD == 8 ? 3 : 0] && v[16:0] == RXD, "R9 overflow set", v, 32'h20008);
    wr(5'h10, 32'h0002_0000);
    rd(5'h10, v); chk(v[17:0] == RXD, "R9 overflow cleared", v, RXD);
    wr(5'h0C, 0);
    for (int k = 0; k < RXD; k++) begin
      rd(5'h08, v); chk(v == (32'h5500_0000 | k), "R9 kept words", v, 32'h5500_0000 | k);
    end
    rd(5'h10, v); chk(v[16:0] == 0, "R9 ninth dropped", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule